// File: doc/BRIEF.md
# External Bus Hold Controller

This block decides who owns a shared external address/data bus: the on-chip CPU bus interface, or an outside master that asks for the bus over an active-low request line. When the CPU owns the bus, the block also breaks each CPU access into the bus cycles the selected region width allows. The width is 8 or 16 bits. Each cycle gets its address and its byte lanes.

The outside master pulls its request low. If the hold function is enabled, the block finishes the whole transaction in progress and then turns off the pin drive enables. One clock later it pulls its acknowledge low. When the request returns high, the acknowledge goes high first and the drive enables come back one clock later. A CPU request made while the bus is away, or while a transaction is running, sees a busy flag and waits. A split access or a locked read-modify-write is never interrupted, so a hold can only begin at a transaction boundary.

Top module: `hold_bus_ctrl`

## Requirements
- R1: While reset is held, and just after it is released, `hold_ack_n` is 1, `bus_oe` is 1, `bus_cyc` is 0, `bus_be` is 0 and `cpu_busy` is 0.
- R2: With `hold_en` at 1, a low `hold_req_n` leads to `hold_ack_n` going low. While `hold_ack_n` is low, `bus_oe` is 0 and no bus cycle runs.
- R3: `hold_ack_n` falls exactly one clock after `bus_oe` falls. The request passes through SYNC_STAGES flops. Once the synchronised request is seen high, `hold_ack_n` rises, and `bus_oe` rises one clock after that.
- R4: On a 16-bit region (`cpu_w16`=1), the number of bus cycles is as follows. A byte or an even halfword takes 1. An even word takes 2. An odd halfword takes 2. An odd word takes 3.
- R5: On an 8-bit region (`cpu_w16`=0), an access takes one bus cycle per byte: 1, 2 or 4 for `cpu_size` 0, 1 or 2. A `cpu_size` of 3 is treated as a word.
- R6: Each bus cycle puts the address of its lowest byte on `bus_addr`, and consecutive cycles follow back to back. On a 16-bit region, `bus_be` bit 0 is the even byte and bit 1 is the odd byte. On an 8-bit region, `bus_be` is 2'b01. Addresses wrap at 2^ADDR_W.
- R7: The hold request is acted on only when no transaction is in flight, or in the clock where the last cycle of a transaction is issued. There is never a free clock or a hold between the cycles of one transaction.
- R8: When `cpu_lock` is set, the access runs its read cycles (`bus_wr`=0) and then repeats the same cycles as writes (`bus_wr`=1) in the very next clock. There is no gap between the two, and `cpu_wr` is ignored.
- R9: While `hold_en` is 0, `hold_req_n` has no effect and `hold_ack_n` is 1 from the next clock on.
- R10: `cpu_busy` is 1 whenever a transaction is in flight, the bus is not owned, or a hold is pending. A request made while `cpu_busy` is 0 starts its first bus cycle on the next clock. A stalled request is served once the bus is back.
- R11: If a pending hold and an idle-time CPU request coincide, the hold wins. The CPU request waits until the bus returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_en | input | 1 | Enables the hold handshake pins |
| hold_req_n | input | 1 | Bus request from the outside master, active low |
| hold_ack_n | output | 1 | Hold acknowledge, active low |
| cpu_req | input | 1 | CPU access request |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| cpu_wr | input | 1 | 1 write, 0 read |
| cpu_lock | input | 1 | Read-modify-write access |
| cpu_w16 | input | 1 | Region width: 1 = 16-bit, 0 = 8-bit |
| cpu_busy | output | 1 | Request cannot be taken this clock |
| bus_oe | output | 1 | Drive enable for address, data and strobe pins |
| bus_cyc | output | 1 | A bus cycle runs this clock |
| bus_addr | output | ADDR_W | Byte address of the current cycle |
| bus_be | output | 2 | Byte lane enables of the current cycle |
| bus_wr | output | 1 | Current cycle is a write |

## Verification
Two events can fall in the same clock. One is the end of a transaction or an idle CPU request, and the other is the synchronised hold request turning active. The bench provokes this by lowering `hold_req_n` at a sweep of offsets relative to a CPU request and to multi-cycle and locked accesses, so that the hold lands on the last cycle, on a middle cycle and on the idle clock. A behavioural model tracks each case with its own queue of planned bus cycles and its own ownership phase. Its outputs are compared with the design on every clock, and the bus cycle count of each transaction is checked against the width table.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    ARB_OWN  = 2'd0,
    ARB_REL  = 2'd1,
    ARB_HOLD = 2'd2,
    ARB_REST = 2'd3
  } arb_state_e;

  localparam int unsigned REM_W = 3;

  // bytes carried by an access of the given size code
  function automatic logic [REM_W-1:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // bytes moved by one bus cycle starting at lane a0 with rem bytes left
  function automatic logic [1:0] chunk_bytes(input logic a0,
                                             input logic [REM_W-1:0] rem,
                                             input logic w16);
    if (!w16 || a0 || rem < 3'd2) return 2'd1;
    return 2'd2;
  endfunction

  // lane mask for one bus cycle, little-endian lanes
  function automatic logic [1:0] chunk_lanes(input logic a0,
                                             input logic [1:0] nb,
                                             input logic w16);
    if (!w16)      return 2'b01;
    if (a0)        return 2'b10;
    if (nb == 2'd2) return 2'b11;
    return 2'b01;
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      logic [STAGES:0]   nxt;
      assign nxt = {sr, d};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= nxt[STAGES-1:0];
      end
      assign q = nxt[STAGES];
    end
  endgenerate
endmodule

// File: rtl/hb_arb.sv
module hb_arb
  import hb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pend,
  input  logic seq_active,
  input  logic seq_last,
  input  logic cpu_req,
  output logic drive_en,
  output logic ack_n,
  output logic accept,
  output logic busy
);
  arb_state_e st_q, st_d;
  logic       free;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ARB_OWN:  if (pend && (!seq_active || seq_last)) st_d = ARB_REL;
      ARB_REL:  st_d = pend ? ARB_HOLD : ARB_REST;
      ARB_HOLD: if (!pend) st_d = ARB_REST;
      ARB_REST: st_d = ARB_OWN;
      default:  st_d = ARB_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ARB_OWN;
    else        st_q <= st_d;
  end

  assign free     = (st_q == ARB_OWN) && !seq_active && !pend;
  assign accept   = free && cpu_req;
  assign busy     = !free;
  assign drive_en = (st_q == ARB_OWN);
  assign ack_n    = (st_q != ARB_HOLD);
endmodule

// File: rtl/hb_seq.sv
module hb_seq
  import hb_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  input  logic              ld_wr,
  input  logic              ld_lock,
  input  logic              ld_w16,
  output logic              active,
  output logic              last,
  output logic              turn,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [1:0]        cyc_be,
  output logic              cyc_wr
);
  logic [ADDR_W-1:0] a_q, base_q;
  logic [REM_W-1:0]  rem_q, tot_q;
  logic              wr_q, lock_q, w16_q, act_q;
  logic [1:0]        nb;
  logic              chunk_end, read_phase;

  assign nb         = chunk_bytes(a_q[0], rem_q, w16_q);
  assign chunk_end  = ({1'b0, nb} == rem_q);
  assign read_phase = lock_q && !wr_q;
  assign turn       = act_q && chunk_end && read_phase;
  assign last       = act_q && chunk_end && !read_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      a_q    <= '0;
      base_q <= '0;
      rem_q  <= '0;
      tot_q  <= '0;
      wr_q   <= 1'b0;
      lock_q <= 1'b0;
      w16_q  <= 1'b0;
    end else if (load) begin
      act_q  <= 1'b1;
      a_q    <= ld_addr;
      base_q <= ld_addr;
      rem_q  <= size_bytes(ld_size);
      tot_q  <= size_bytes(ld_size);
      wr_q   <= ld_wr && !ld_lock;
      lock_q <= ld_lock;
      w16_q  <= ld_w16;
    end else if (act_q) begin
      if (turn) begin
        a_q   <= base_q;
        rem_q <= tot_q;
        wr_q  <= 1'b1;
      end else if (last) begin
        act_q <= 1'b0;
      end else begin
        a_q   <= a_q + {{(ADDR_W-2){1'b0}}, nb};
        rem_q <= rem_q - {1'b0, nb};
      end
    end
  end

  assign active   = act_q;
  assign cyc_addr = act_q ? a_q : '0;
  assign cyc_be   = act_q ? chunk_lanes(a_q[0], nb, w16_q) : 2'b00;
  assign cyc_wr   = act_q && wr_q;
endmodule

// File: rtl/hold_bus_ctrl.sv
module hold_bus_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_en,
  input  logic              hold_req_n,
  output logic              hold_ack_n,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  input  logic              cpu_wr,
  input  logic              cpu_lock,
  input  logic              cpu_w16,
  output logic              cpu_busy,
  output logic              bus_oe,
  output logic              bus_cyc,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_be,
  output logic              bus_wr
);
  // named internal events, also used by the bound checker
  logic req_seen;
  logic pend;
  logic seq_active;
  logic seq_last;
  logic lock_turn;
  logic accept;

  hb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (~hold_req_n),
    .q     (req_seen)
  );

  assign pend = hold_en && req_seen;

  hb_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend       (pend),
    .seq_active (seq_active),
    .seq_last   (seq_last),
    .cpu_req    (cpu_req),
    .drive_en   (bus_oe),
    .ack_n      (hold_ack_n),
    .accept     (accept),
    .busy       (cpu_busy)
  );

  hb_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .ld_addr  (cpu_addr),
    .ld_size  (cpu_size),
    .ld_wr    (cpu_wr),
    .ld_lock  (cpu_lock),
    .ld_w16   (cpu_w16),
    .active   (seq_active),
    .last     (seq_last),
    .turn     (lock_turn),
    .cyc_addr (bus_addr),
    .cyc_be   (bus_be),
    .cyc_wr   (bus_wr)
  );

  assign bus_cyc = seq_active;
endmodule

// File: rtl/hold_bus_ctrl_chk.sv
module hold_bus_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hold_en,
  input logic       hold_ack_n,
  input logic       bus_oe,
  input logic       bus_cyc,
  input logic       bus_wr,
  input logic [1:0] bus_be,
  input logic       cpu_req,
  input logic       cpu_busy,
  input logic       seq_last,
  input logic       lock_turn
);
  p_hold_floats_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack_n |-> (!bus_oe && !bus_cyc));

  p_ack_after_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> $past(!bus_oe));

  p_drive_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(hold_ack_n));

  p_lanes_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> (bus_be != 2'b00));

  p_no_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !seq_last) |=> (bus_cyc && hold_ack_n));

  p_rmw_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_turn |=> (bus_cyc && bus_wr));

  p_disabled_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_en |=> hold_ack_n);

  p_accept_starts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_busy) |=> bus_cyc);
endmodule

bind hold_bus_ctrl hold_bus_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hold_en    (hold_en),
  .hold_ack_n (hold_ack_n),
  .bus_oe     (bus_oe),
  .bus_cyc    (bus_cyc),
  .bus_wr     (bus_wr),
  .bus_be     (bus_be),
  .cpu_req    (cpu_req),
  .cpu_busy   (cpu_busy),
  .seq_last   (seq_last),
  .lock_turn  (lock_turn)
);

// File: tb/hold_bus_ctrl_test.sv
module hold_bus_ctrl_test;
  localparam int AW   = 20;
  localparam int SS   = 2;
  localparam int MASK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n, hold_en, hold_req_n, cpu_req, cpu_wr, cpu_lock, cpu_w16;
  logic [AW-1:0] cpu_addr;
  logic [1:0]    cpu_size;
  logic          hold_ack_n, cpu_busy, bus_oe, bus_cyc, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_be;

  always #5 clk = ~clk;

  hold_bus_ctrl #(.ADDR_W(AW), .SYNC_STAGES(SS)) uut (
    .clk(clk), .rst_n(rst_n), .hold_en(hold_en), .hold_req_n(hold_req_n),
    .hold_ack_n(hold_ack_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_size(cpu_size), .cpu_wr(cpu_wr), .cpu_lock(cpu_lock), .cpu_w16(cpu_w16),
    .cpu_busy(cpu_busy), .bus_oe(bus_oe), .bus_cyc(bus_cyc), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wr(bus_wr)
  );

  int    n_run = 0, n_fail = 0, cyc_cnt = 0, ticks = 0;
  bit    done = 0;
  string tag = "R1";

  typedef struct { int addr; int be; int wr; } cyc_t;
  cyc_t q[$];
  int   mode;           // 0 bus owned, 1 releasing, 2 held, 3 restoring
  bit   sync_s[SS];

  task automatic chk(bit ok, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // list every bus cycle an access must produce
  function automatic void plan(int addr, int size, bit wr, bit lock, bit w16);
    int n, phases;
    n = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    phases = lock ? 2 : 1;
    for (int ph = 0; ph < phases; ph++) begin
      bit w;
      w = lock ? (ph == 1) : wr;
      if (!w16) begin
        for (int i = 0; i < n; i++) q.push_back('{(addr + i) & MASK, 1, int'(w)});
      end else begin
        for (int h = addr & ~1; h <= ((addr + n - 1) & ~1); h += 2) begin
          int be;
          be = 0;
          if (h >= addr) be |= 1;
          if (h + 1 <= addr + n - 1) be |= 2;
          q.push_back('{((be & 1) != 0 ? h : h + 1) & MASK, be, int'(w)});
        end
      end
    end
  endfunction

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    bit pend, idle;
    if (!rst_n) begin
      q.delete();
      mode = 0;
      for (int i = 0; i < SS; i++) sync_s[i] = 0;
    end else begin
      pend = hold_en && sync_s[SS-1];
      idle = (mode == 0) && (q.size() == 0) && !pend;
      for (int i = SS - 1; i > 0; i--) sync_s[i] = sync_s[i-1];
      sync_s[0] = !hold_req_n;
      case (mode)
        0: begin
          if (q.size() != 0) begin
            void'(q.pop_front());
            if (q.size() == 0 && pend) mode = 1;
          end else if (pend) mode = 1;
          else if (idle && cpu_req) plan(int'(cpu_addr), int'(cpu_size), cpu_wr, cpu_lock, cpu_w16);
        end
        1: mode = pend ? 2 : 3;
        2: if (!pend) mode = 3;
        default: mode = 0;
      endcase
    end
  end

  // compare with the model away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      bit e_cyc, e_busy;
      e_cyc  = (mode == 0) && (q.size() != 0);
      e_busy = !((mode == 0) && (q.size() == 0) && !(hold_en && sync_s[SS-1]));
      chk(bus_oe == (mode == 0), "bus_oe", int'(bus_oe), int'(mode == 0));
      chk(hold_ack_n == (mode != 2), "hold_ack_n", int'(hold_ack_n), int'(mode != 2));
      chk(bus_cyc == e_cyc, "bus_cyc", int'(bus_cyc), int'(e_cyc));
      chk(cpu_busy == e_busy, "cpu_busy", int'(cpu_busy), int'(e_busy));
      if (e_cyc) begin
        chk(int'(bus_addr) == q[0].addr, "bus_addr", int'(bus_addr), q[0].addr);
        chk(int'(bus_be) == q[0].be, "bus_be", int'(bus_be), q[0].be);
        chk(int'(bus_wr) == q[0].wr, "bus_wr", int'(bus_wr), q[0].wr);
      end else begin
        chk(bus_be == 2'b00 && !bus_wr, "idle lanes", int'(bus_be), 0);
      end
      if (bus_cyc) cyc_cnt++;
    end
  end

  always @(posedge clk) begin
    ticks++;
    if (ticks > 100000 && !done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL %s watchdog expired", tag);
      report();
      $finish;
    end
  end

  task automatic issue(int addr, int size, bit wr, bit lock, bit w16);
    cpu_addr = addr[AW-1:0];
    cpu_size = size[1:0];
    cpu_wr   = wr;
    cpu_lock = lock;
    cpu_w16  = w16;
    cpu_req  = 1'b1;
    while (cpu_busy) @(negedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic run_txn(string t, int addr, int size, bit wr, bit lock, bit w16, int exp);
    tag = t;
    @(negedge clk);
    cyc_cnt = 0;
    issue(addr, size, wr, lock, w16);
    repeat (12) @(negedge clk);
    chk(cyc_cnt == exp, "bus cycle count", cyc_cnt, exp);
  endtask

  initial begin
    rst_n = 0; hold_en = 1; hold_req_n = 1; cpu_req = 0;
    cpu_addr = '0; cpu_size = 0; cpu_wr = 0; cpu_lock = 0; cpu_w16 = 1;
    repeat (3) @(negedge clk);
    tag = "R1";
    chk(hold_ack_n && bus_oe && !bus_cyc && bus_be == 0 && !cpu_busy,
        "reset outputs", int'({hold_ack_n, bus_oe, bus_cyc, cpu_busy}), 4'b1100);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R4 16-bit region widths
    run_txn("R4", 'h100, 2, 0, 0, 1, 2);
    run_txn("R4", 'h103, 2, 1, 0, 1, 3);
    run_txn("R4", 'h105, 1, 0, 0, 1, 2);
    run_txn("R4", 'h106, 1, 1, 0, 1, 1);
    run_txn("R4", 'h107, 0, 0, 0, 1, 1);
    // R5 8-bit region
    run_txn("R5", 'h201, 2, 0, 0, 0, 4);
    run_txn("R5", 'h203, 1, 1, 0, 0, 2);
    run_txn("R5", 'h204, 0, 0, 0, 0, 1);
    run_txn("R5", 'h208, 3, 1, 0, 0, 4);
    // R6 wrap at the top of the address space
    run_txn("R6", MASK, 2, 0, 0, 1, 3);
    run_txn("R6", MASK - 1, 2, 1, 0, 0, 4);
    // R8 locked read-modify-write, cpu_wr ignored
    run_txn("R8", 'h301, 0, 1, 1, 1, 2);
    run_txn("R8", 'h303, 2, 0, 1, 1, 6);
    run_txn("R8", 'h305, 1, 1, 1, 0, 4);

    // R2 / R3 plain hold and release
    tag = "R2";
    @(negedge clk); hold_req_n = 0;
    repeat (10) @(negedge clk);
    chk(!hold_ack_n && !bus_oe, "hold granted", int'({hold_ack_n, bus_oe}), 0);
    tag = "R3";
    hold_req_n = 1;
    repeat (8) @(negedge clk);
    chk(hold_ack_n && bus_oe, "bus restored", int'({hold_ack_n, bus_oe}), 3);

    // R7 hold raised at every offset inside long accesses
    for (int k = 0; k < 6; k++) begin
      tag = "R7";
      @(negedge clk);
      cyc_cnt = 0;
      fork
        issue('h401, 2, 0, 0, 0);
        begin repeat (k) @(negedge clk); hold_req_n = 0; repeat (9) @(negedge clk); hold_req_n = 1; end
      join
      repeat (14) @(negedge clk);
      chk(cyc_cnt == 4, "bus cycle count", cyc_cnt, 4);
    end
    for (int k = 0; k < 6; k++) begin
      tag = "R8";
      @(negedge clk);
      cyc_cnt = 0;
      fork
        issue('h503, 2, 0, 1, 1);
        begin repeat (k) @(negedge clk); hold_req_n = 0; repeat (9) @(negedge clk); hold_req_n = 1; end
      join
      repeat (14) @(negedge clk);
      chk(cyc_cnt == 6, "bus cycle count", cyc_cnt, 6);
    end

    // R11 / R10 hold and CPU request at shifting offsets
    for (int k = 0; k < 5; k++) begin
      tag = (k < 3) ? "R11" : "R10";
      @(negedge clk);
      cyc_cnt = 0;
      fork
        begin hold_req_n = 0; repeat (10) @(negedge clk); hold_req_n = 1; end
        begin repeat (k) @(negedge clk); issue('h600 + k, 1, 1, 0, 1); issue('h610, 0, 0, 0, 0); end
      join
      repeat (14) @(negedge clk);
      chk(cyc_cnt == ((k % 2 == 1) ? 3 : 2), "bus cycle count", cyc_cnt, (k % 2 == 1) ? 3 : 2);
    end

    // R9 handshake disabled
    tag = "R9";
    @(negedge clk); hold_en = 0; hold_req_n = 0;
    repeat (6) @(negedge clk);
    chk(hold_ack_n && bus_oe, "ignored request", int'({hold_ack_n, bus_oe}), 3);
    run_txn("R9", 'h701, 2, 0, 0, 1, 3);
    hold_en = 1;
    repeat (8) @(negedge clk);
    chk(!hold_ack_n, "hold after enable", int'(hold_ack_n), 0);
    hold_en = 0;
    @(negedge clk);
    chk(hold_ack_n, "ack drops with enable", int'(hold_ack_n), 1);
    hold_req_n = 1;
    repeat (6) @(negedge clk);

    done = 1;
    report();
    $finish;
  end
endmodule